// File: doc/BRIEF.md
# Ordered Read-Address Unlock Detector

This block sits beside a memory's host port and observes every finished access. Each access is reported by a single-cycle strobe, a flag telling read from write, and a 13-bit address. The detector looks for a fixed ordered chain of six reads. The first five addresses are common to both commands. The sixth address chooses the command: one value asks for a nonvolatile store and the other asks for a recall. When the chain completes, the block raises a one-cycle start pulse for the chosen command.

Any access that departs from the chain throws away the progress. The only exception is a read of the first key address, which begins a new attempt at once. While the store or recall engine reports busy, the detector stays in its idle state and ignores accesses. The detector does not perform the copy and has no memory array of its own.

The state machine has six named states. `S_IDLE` means no key has been matched. `S_K1` to `S_K5` mean one to five keys have been matched in order. The named transitions are as follows:
- ADVANCE goes from `S_IDLE`..`S_K4` to the next state on a read of the expected key.
- FIRE goes from `S_K5` to `S_IDLE` on a read of a command address and raises a pulse.
- RESTART goes to `S_K1` on a breaking read of 0x0000.
- ABORT goes to `S_IDLE` on any other breaking access.
- HOLD keeps the state on a cycle with no strobe.
- BUSY goes to `S_IDLE` whenever the busy input is high.

Top module: `unlock_seq_detector`

## Requirements
- R1: After reset the detector is in `S_IDLE` with both pulses low, so a lone read of 0x0F0F or 0x0F0E issues no pulse.
- R2: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F, in that order, raise `store_start` for exactly one cycle, in the cycle after the clock edge that samples the sixth strobe.
- R3: The same five reads followed by a read of 0x0F0E raise `recall_start` for exactly one cycle, with the same timing as R2.
- R4: `store_start` and `recall_start` are never high together, and neither is high for two cycles in a row.
- R5: A write (`acc_write`=1) at any address, including the expected key, aborts the sequence and issues no pulse.
- R6: A read of an address other than the next expected key aborts the sequence, so a later completion needs a fresh run of all six reads.
- R7: A breaking read of 0x0000 counts as step one of a new attempt.
- R8: A sixth read at an address other than 0x0F0F or 0x0F0E issues no pulse and aborts the sequence.
- R9: While `nv_busy` is high the detector returns to `S_IDLE`, ignores accesses and raises no pulse.
- R10: After a pulse the detector is in `S_IDLE`, so a further command-address read alone issues nothing.
- R11: Cycles with `acc_valid` low leave the progress unchanged, so idle gaps between steps do not break the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One-cycle strobe for a completed, chip-enabled access |
| acc_write | input | 1 | 1 = write, 0 = read, valid with the strobe |
| acc_addr | input | 13 | Access address, valid with the strobe |
| nv_busy | input | 1 | Store or recall in progress; holds the detector idle |
| store_start | output | 1 | One-cycle request to start a store |
| recall_start | output | 1 | One-cycle request to start a recall |

## Verification
The only visible symptoms of a wrong internal state are pulses that are missing, extra or late. A state that has advanced too far fires one read early. A state that fails to abort fires after a broken chain. A lost RESTART shows up only when the following five reads complete. Because of this, the bench runs a behavioural reference model and compares both pulse outputs on every clock. Every mismatch is therefore caught one cycle after the strobe that exposes it. Random streams biased toward the key addresses reach the deeper states often.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;
    localparam int ADDR_W   = 13;
    localparam int N_PREFIX = 5;
    localparam int STEP_W   = $clog2(N_PREFIX + 1);

    typedef enum logic [STEP_W-1:0] {
        S_IDLE = 3'd0,
        S_K1   = 3'd1,
        S_K2   = 3'd2,
        S_K3   = 3'd3,
        S_K4   = 3'd4,
        S_K5   = 3'd5
    } seq_state_t;

    localparam logic [ADDR_W-1:0] KEY_STORE  = 13'h0F0F;
    localparam logic [ADDR_W-1:0] KEY_RECALL = 13'h0F0E;

    function automatic logic [ADDR_W-1:0] prefix_key(input logic [STEP_W-1:0] idx);
        logic [ADDR_W-1:0] k;
        unique case (idx)
            3'd0:    k = 13'h0000;
            3'd1:    k = 13'h1555;
            3'd2:    k = 13'h0AAA;
            3'd3:    k = 13'h1FFF;
            3'd4:    k = 13'h10F0;
            default: k = 13'h0000;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/seq_key_match.sv
module seq_key_match
    import unlock_seq_pkg::*;
(
    input  logic [STEP_W-1:0] step_idx,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_expected,
    output logic              hit_first,
    output logic              hit_store,
    output logic              hit_recall
);
    logic [ADDR_W-1:0] want;

    always_comb begin
        want         = prefix_key(step_idx);
        hit_expected = (addr == want);
        hit_first    = (addr == prefix_key('0));
        hit_store    = (addr == KEY_STORE);
        hit_recall   = (addr == KEY_RECALL);
    end
endmodule

// File: rtl/seq_step_fsm.sv
module seq_step_fsm
    import unlock_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              busy,
    input  logic              hit_expected,
    input  logic              hit_first,
    input  logic              hit_store,
    input  logic              hit_recall,
    output logic [STEP_W-1:0] step_idx,
    output logic              store_pulse,
    output logic              recall_pulse
);
    seq_state_t state, state_nxt;
    logic       fire_store, fire_recall;
    logic       is_read;

    assign is_read  = acc_valid && !acc_write;
    assign step_idx = state;

    always_comb begin
        state_nxt   = state;
        fire_store  = 1'b0;
        fire_recall = 1'b0;
        if (busy) begin
            state_nxt = S_IDLE;
        end else if (acc_valid) begin
            if (is_read && state != S_K5 && hit_expected) begin
                state_nxt = seq_state_t'(state + 3'd1);
            end else if (is_read && state == S_K5 && hit_store) begin
                fire_store = 1'b1;
                state_nxt  = S_IDLE;
            end else if (is_read && state == S_K5 && hit_recall) begin
                fire_recall = 1'b1;
                state_nxt   = S_IDLE;
            end else if (is_read && hit_first) begin
                state_nxt = S_K1;
            end else begin
                state_nxt = S_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_pulse  <= 1'b0;
            recall_pulse <= 1'b0;
        end else begin
            store_pulse  <= fire_store;
            recall_pulse <= fire_recall;
        end
    end

    a_r11_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !busy) |=> $stable(state));
    a_r10_idle_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (store_pulse || recall_pulse) |-> state == S_IDLE);
    a_r9_busy_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (state == S_IDLE && !store_pulse && !recall_pulse));
    a_r5_write_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> (state == S_IDLE && !store_pulse && !recall_pulse));
    a_r2_pulse_needs_k5_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !busy && state == S_K5 && hit_store) |=> store_pulse);
endmodule

// File: rtl/unlock_seq_detector.sv
module unlock_seq_detector
    import unlock_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              nv_busy,
    output logic              store_start,
    output logic              recall_start
);
    logic [STEP_W-1:0] step_idx;
    logic hit_expected, hit_first, hit_store, hit_recall;

    seq_key_match u_match (
        .step_idx     (step_idx),
        .addr         (acc_addr),
        .hit_expected (hit_expected),
        .hit_first    (hit_first),
        .hit_store    (hit_store),
        .hit_recall   (hit_recall)
    );

    seq_step_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_write    (acc_write),
        .busy         (nv_busy),
        .hit_expected (hit_expected),
        .hit_first    (hit_first),
        .hit_store    (hit_store),
        .hit_recall   (hit_recall),
        .step_idx     (step_idx),
        .store_pulse  (store_start),
        .recall_pulse (recall_start)
    );

    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_start, recall_start}));
    a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (store_start || recall_start) |=> !(store_start || recall_start));
    a_r1_pulse_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        (store_start || recall_start) |-> $past(acc_valid && !acc_write && !nv_busy));
endmodule

// File: tb/tb_unlock_seq_detector.sv
module tb_unlock_seq_detector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [12:0] acc_addr = '0;
    logic        nv_busy = 1'b0;
    logic        store_start, recall_start;

    int n_checks = 0;
    int n_fail   = 0;
    int prog     = 0;
    logic [12:0] keys [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};

    always #5 clk = ~clk;

    unlock_seq_detector dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .nv_busy(nv_busy),
        .store_start(store_start), .recall_start(recall_start)
    );

    task automatic check(input string tag, input logic es, input logic er);
        n_checks++;
        if (store_start !== es || recall_start !== er) begin
            n_fail++;
            $display("FAIL %s: store/recall actual %b%b expected %b%b",
                     tag, store_start, recall_start, es, er);
        end
    endtask

    task automatic cyc(input string tag, input logic v, input logic w,
                       input logic [12:0] a, input logic b);
        logic es, er;
        acc_valid = v; acc_write = w; acc_addr = a; nv_busy = b;
        es = 1'b0; er = 1'b0;
        if (b) prog = 0;
        else if (v) begin
            if (!w && prog < 5 && a == keys[prog]) prog++;
            else if (!w && prog == 5 && a == 13'h0F0F) begin es = 1'b1; prog = 0; end
            else if (!w && prog == 5 && a == 13'h0F0E) begin er = 1'b1; prog = 0; end
            else prog = (!w && a == 13'h0000) ? 1 : 0;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, es, er);
    endtask

    task automatic rd(input string tag, input logic [12:0] a);
        cyc(tag, 1'b1, 1'b0, a, 1'b0);
    endtask

    task automatic prefix(input string tag);
        for (int i = 0; i < 5; i++) rd(tag, keys[i]);
    endtask

    task automatic gap(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 1'b0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", 1'b0, 1'b0);
        rst_n = 1'b1;
        rd("R1 lone store addr", 13'h0F0F);
        rd("R1 lone recall addr", 13'h0F0E);
        prefix("R2 prefix"); rd("R2 store fires", 13'h0F0F);
        gap("R4 pulse one cycle", 1);
        prefix("R3 prefix"); rd("R3 recall fires", 13'h0F0E);
        rd("R10 no refire", 13'h0F0E);
        rd("R10 no refire store", 13'h0F0F);
        for (int i = 0; i < 5; i++) begin rd("R11 gapped", keys[i]); gap("R11 gap", i); end
        rd("R11 gapped store", 13'h0F0F);
        rd("R5 k0", 13'h0000); rd("R5 k1", 13'h1555);
        cyc("R5 write at key", 1'b1, 1'b1, 13'h0AAA, 1'b0);
        rd("R5 after write", 13'h0AAA); rd("R5 k3", 13'h1FFF); rd("R5 k4", 13'h10F0);
        rd("R5 no fire", 13'h0F0F);
        prefix("R5 write at sixth");
        cyc("R5 write sixth", 1'b1, 1'b1, 13'h0F0F, 1'b0);
        rd("R5 sixth after write", 13'h0F0F);
        rd("R6 k0", 13'h0000); rd("R6 k1", 13'h1555); rd("R6 wrong", 13'h0AAB);
        rd("R6 k3", 13'h1FFF); rd("R6 k4", 13'h10F0); rd("R6 no fire", 13'h0F0F);
        rd("R7 k0", 13'h0000); rd("R7 k1", 13'h1555); rd("R7 k2", 13'h0AAA);
        rd("R7 restart", 13'h0000);
        for (int i = 1; i < 5; i++) rd("R7 continue", keys[i]);
        rd("R7 store after restart", 13'h0F0F);
        rd("R7 double k0", 13'h0000); prefix("R7 double k0 prefix");
        rd("R7 recall after double", 13'h0F0E);
        prefix("R8 prefix"); rd("R8 bad sixth", 13'h0F0D);
        rd("R8 after bad", 13'h0F0F);
        prefix("R8 sixth is k0"); rd("R8 sixth k0", 13'h0000);
        for (int i = 1; i < 5; i++) rd("R8 continue", keys[i]);
        rd("R8 recall", 13'h0F0E);
        rd("R9 k0", 13'h0000); rd("R9 k1", 13'h1555);
        cyc("R9 busy", 1'b0, 1'b0, '0, 1'b1);
        rd("R9 k2 after busy", 13'h0AAA);
        prefix("R9 prefix");
        cyc("R9 busy at sixth", 1'b1, 1'b0, 13'h0F0F, 1'b1);
        cyc("R9 busy read k0", 1'b1, 1'b0, 13'h0000, 1'b1);
        rd("R9 after busy", 13'h1555);
        for (int n = 0; n < 20000; n++) begin
            int r = $urandom_range(0, 15);
            logic [12:0] a;
            if (r < 10) a = (prog < 5) ? keys[prog] : ((r & 1) ? 13'h0F0F : 13'h0F0E);
            else if (r < 12) a = 13'h0000;
            else a = 13'($urandom);
            cyc("R4 random", ($urandom_range(0, 7) != 0), ($urandom_range(0, 31) == 0),
                a, ($urandom_range(0, 63) == 0));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule